// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the software-facing control point of one DMA channel. A processor reaches it through a 32-bit register window that accepts only full-word accesses. The window holds a command/status word and six pointer registers. The command/status word is not written like a plain register. Each write is decoded as separate command bits, and those bits set or clear sticky flags for enable, update, complete and transfer direction. The pointer registers are the working address, the limit, the start, the stop, the initial working address and a size word. Each of them stores whatever is written to it.

A minimal engine is included so that completion can be observed. While the channel is enabled it accepts data beats from the datapath. Each accepted beat moves the working address forward by one word. When the working address lands on the limit, the channel turns itself off and raises a completion flag. That flag drives a level interrupt. The chip instantiates the block once for the storage channel and once for the network receive channel.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, all four flags are clear, every pointer register reads zero, `irqDone`, `beatReady` and `devToMem` are low, and the command/status word reads zero.
- R2: A legal write to offset 0x0000 with bit 0 set sets the enable flag, which reads back on bit 24. A write with bit 0 clear leaves the flag unchanged.
- R3: A command write with bit 4 set sets the direction flag (bit 24+3 = bit 27, also driven on `devToMem`). A command write with bit 1 set sets the update flag (bit 25). Both flags stay set until a reset command.
- R4: A command write with bit 2 set clears the complete flag (bit 26) and changes no other flag.
- R5: A command write with bit 3 set clears enable, update, complete and direction together. This holds even when set bits appear in the same write.
- R6: The pointer registers sit at byte offsets 0x4000 (working address), 0x4004 (limit), 0x4008 (start), 0x400C (stop), 0x4200 (initial working address) and 0x4204 (size). Each stores and reads back all 32 bits.
- R7: An access takes effect only when `regByteEn` is 4'hF and `regAddr[1:0]` is 0. Any other access writes nothing and reads zero. Offsets outside the map read zero and ignore writes.
- R8: `beatReady` equals the enable flag. Each cycle with `beatValid` high while the channel is enabled adds 4 to the working address. While the channel is disabled, beats are refused and the address holds.
- R9: If an accepted beat makes the working address equal to the limit, then at that same clock edge the enable flag clears and the complete flag sets. The comparison uses the values the registers held before the edge.
- R10: `irqDone` is high exactly when the complete flag is set.
- R11: In one cycle, a register write to the working address overrides the beat advance. Command bits in a write are applied after the completion update from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register access strobe |
| regWr | input | 1 | 1 = write, 0 = read |
| regAddr | input | 15 | Byte offset within the channel window |
| regByteEn | input | 4 | Byte lanes; only 4'hF is legal |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational during a read access |
| beatValid | input | 1 | Datapath offers one data beat |
| beatReady | output | 1 | Channel enabled; a beat is accepted when both are high |
| devToMem | output | 1 | Direction flag: device to memory |
| irqDone | output | 1 | Level interrupt, high while complete is set |

## Verification
The assertions assume that `regSel`, `regWr` and `beatValid` are held steady for a whole clock period and change only away from the active edge. They also assume that the datapath raises `beatValid` only as an offer and never treats a beat as taken unless `beatReady` is high. The stimulus meets both assumptions: it drives every input on the falling edge and releases it just after the rising edge. Random command words use the full 32 bits, so reset, set and clear bits collide in the same write. The limit and working-address pairs are placed a few words apart, which makes completion happen often. Illegal byte enables and unmapped offsets come up in the random mix as well as in the directed cases.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int NUM_PTR = 6;

  // command bits inside a write to the control/status word
  localparam int CMD_SET_EN   = 0;
  localparam int CMD_SET_UPD  = 1;
  localparam int CMD_CLR_DONE = 2;
  localparam int CMD_RESET    = 3;
  localparam int CMD_DIR      = 4;

  // flag positions in the read-back word
  localparam int FLG_EN   = 24;
  localparam int FLG_UPD  = 25;
  localparam int FLG_DONE = 26;
  localparam int FLG_DIR  = 27;

  localparam int OFF_CSR = 32'h0000;

  // pointer index 0 is the working address, 1 is the limit
  function automatic int ptrOffset(input int idx);
    case (idx)
      0:       return 32'h4000;
      1:       return 32'h4004;
      2:       return 32'h4008;
      3:       return 32'h400C;
      4:       return 32'h4200;
      default: return 32'h4204;
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_PTR-1:0] hit;
    logic               wrEn;
    logic               advance;
  } ptrCtl_t;

endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              beatValid,
  input  logic              lastBeat,
  output ptrCtl_t           ctl,
  output logic              csrHit,
  output logic [DATA_W-1:0] csrWord,
  output logic              enable,
  output logic              dirFlag,
  output logic              doneFlag
);

  logic legalAcc, csrWrite, engineDone;
  logic enQ, updQ, doneQ, dirQ;
  logic enD, updD, doneD, dirD;

  assign legalAcc = regSel && (regByteEn == 4'hF) && (regAddr[1:0] == 2'b00);
  assign csrHit   = legalAcc && (regAddr == ADDR_W'(OFF_CSR));
  assign csrWrite = csrHit && regWr;

  for (genvar i = 0; i < NUM_PTR; i++) begin : gHit
    assign ctl.hit[i] = legalAcc && (regAddr == ADDR_W'(ptrOffset(i)));
  end
  assign ctl.wrEn    = regWr;
  assign ctl.advance = beatValid && enQ;

  assign engineDone = ctl.advance && lastBeat;

  always_comb begin
    enD   = enQ;
    updD  = updQ;
    doneD = doneQ;
    dirD  = dirQ;
    if (engineDone) begin
      enD   = 1'b0;
      doneD = 1'b1;
    end
    if (csrWrite) begin
      if (regWdata[CMD_SET_EN])   enD   = 1'b1;
      if (regWdata[CMD_SET_UPD])  updD  = 1'b1;
      if (regWdata[CMD_DIR])      dirD  = 1'b1;
      if (regWdata[CMD_CLR_DONE]) doneD = 1'b0;
      if (regWdata[CMD_RESET]) begin
        enD   = 1'b0;
        updD  = 1'b0;
        doneD = 1'b0;
        dirD  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      updQ  <= 1'b0;
      doneQ <= 1'b0;
      dirQ  <= 1'b0;
    end else begin
      enQ   <= enD;
      updQ  <= updD;
      doneQ <= doneD;
      dirQ  <= dirD;
    end
  end

  always_comb begin
    csrWord           = '0;
    csrWord[FLG_EN]   = enQ;
    csrWord[FLG_UPD]  = updQ;
    csrWord[FLG_DONE] = doneQ;
    csrWord[FLG_DIR]  = dirQ;
  end

  assign enable   = enQ;
  assign dirFlag  = dirQ;
  assign doneFlag = doneQ;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrite && regWdata[CMD_RESET]) |=> (!enQ && !updQ && !doneQ && !dirQ)); // R5

  AST_DONE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && lastBeat && !csrWrite) |=> (doneQ && !enQ)); // R9

  AST_CLR_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrite && regWdata[CMD_CLR_DONE] && !regWdata[CMD_RESET])
      |=> (!doneQ && updQ == $past(updQ || regWdata[CMD_SET_UPD]))); // R4

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && !csrWrite && !(ctl.advance && lastBeat)) |=> enQ); // R2

  AST_DIR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (dirQ && !(csrWrite && regWdata[CMD_RESET])) |=> dirQ); // R3

endmodule

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptrCtl_t           ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ptrRd,
  output logic              lastBeat
);

  localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

  logic [NUM_PTR-1:0][DATA_W-1:0] rdTerm;
  logic [DATA_W-1:0] nextQ, limitQ;

  for (genvar i = 0; i < NUM_PTR; i++) begin : gPtr
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        q <= '0;
      end else if (ctl.wrEn && ctl.hit[i]) begin
        q <= wrData;
      end else if ((i == 0) && ctl.advance) begin
        q <= q + STEP_V;
      end
    end
    assign rdTerm[i] = ctl.hit[i] ? q : '0;
  end

  assign nextQ  = gPtr[0].q;
  assign limitQ = gPtr[1].q;

  assign lastBeat = (nextQ + STEP_V) == limitQ;

  always_comb begin
    ptrRd = '0;
    for (int i = 0; i < NUM_PTR; i++) ptrRd = ptrRd | rdTerm[i];
  end

  AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !(ctl.wrEn && ctl.hit[0])) |=> nextQ == $past(nextQ) + STEP_V); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.advance && !(ctl.wrEn && ctl.hit[0])) |=> $stable(nextQ)); // R8

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEn && ctl.hit[0]) |=> nextQ == $past(wrData)); // R11

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              beatValid,
  output logic              beatReady,
  output logic              devToMem,
  output logic              irqDone
);

  ptrCtl_t           ctl;
  logic              csrHit, lastBeat, enable, dirFlag, doneFlag;
  logic [DATA_W-1:0] csrWord, ptrRd;

  dma_chan_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regSel    (regSel),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regByteEn (regByteEn),
    .regWdata  (regWdata),
    .beatValid (beatValid),
    .lastBeat  (lastBeat),
    .ctl       (ctl),
    .csrHit    (csrHit),
    .csrWord   (csrWord),
    .enable    (enable),
    .dirFlag   (dirFlag),
    .doneFlag  (doneFlag)
  );

  dma_chan_dp #(.DATA_W(DATA_W), .STEP(STEP)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrData   (regWdata),
    .ptrRd    (ptrRd),
    .lastBeat (lastBeat)
  );

  always_comb begin
    regRdata = '0;
    if (regSel && !regWr) regRdata = csrHit ? csrWord : ptrRd;
  end

  assign beatReady = enable;
  assign devToMem  = dirFlag;
  assign irqDone   = doneFlag;

  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatReady && lastBeat && !(regSel && regWr)) |=> irqDone); // R10

endmodule

// File: tb/sim_dma_chan_regs.sv
`timescale 1ns/1ps
module sim_dma_chan_regs;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regSel, regWr, beatValid;
  logic [14:0] regAddr;
  logic [3:0]  regByteEn;
  logic [31:0] regWdata, regRdata;
  logic        beatReady, devToMem, irqDone;

  always #4 clk = ~clk;

  dma_chan_regs u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regAddr(regAddr),
    .regByteEn(regByteEn), .regWdata(regWdata), .regRdata(regRdata),
    .beatValid(beatValid), .beatReady(beatReady), .devToMem(devToMem),
    .irqDone(irqDone)
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  logic mEn, mUpd, mDone, mDir;
  logic [31:0] mPtr [6];

  function automatic logic [14:0] offOf(input int idx);
    case (idx)
      0: return 15'h4000;  1: return 15'h4004;  2: return 15'h4008;
      3: return 15'h400C;  4: return 15'h4200;  default: return 15'h4204;
    endcase
  endfunction

  function automatic logic [31:0] csrExp();
    return {4'b0, mDir, mDone, mUpd, mEn, 24'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock cycle of stimulus, model updated with the same priorities
  task automatic cyc(input bit sel, input bit wr, input logic [14:0] addr,
                     input logic [3:0] be, input logic [31:0] data, input bit beat);
    bit legal, adv, last;
    @(negedge clk);
    regSel = sel; regWr = wr; regAddr = addr; regByteEn = be;
    regWdata = data; beatValid = beat;
    @(posedge clk);
    #1;
    regSel = 0; regWr = 0; beatValid = 0;
    legal = sel && be == 4'hF && addr[1:0] == 2'b00;
    adv   = beat && mEn;
    last  = (mPtr[0] + 32'd4) == mPtr[1];
    if (adv) begin
      mPtr[0] = mPtr[0] + 32'd4;
      if (last) begin mEn = 0; mDone = 1; end
    end
    if (legal && wr) begin
      for (int i = 0; i < 6; i++) if (addr == offOf(i)) mPtr[i] = data;
      if (addr == 15'h0) begin
        if (data[0]) mEn = 1;
        if (data[1]) mUpd = 1;
        if (data[4]) mDir = 1;
        if (data[2]) mDone = 0;
        if (data[3]) begin mEn = 0; mUpd = 0; mDone = 0; mDir = 0; end
      end
    end
  endtask

  task automatic rd(input logic [14:0] addr, input logic [3:0] be, output logic [31:0] val);
    @(negedge clk);
    regSel = 1; regWr = 0; regAddr = addr; regByteEn = be; beatValid = 0;
    #1 val = regRdata;
    @(posedge clk);
    #1 regSel = 0;
  endtask

  task automatic wr(input logic [14:0] addr, input logic [31:0] data);
    cyc(1, 1, addr, 4'hF, data, 0);
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] v;
    rd(15'h0, 4'hF, v);
    chk({tag, " csr"}, v, csrExp());
    rd(15'h4000, 4'hF, v);
    chk({tag, " next"}, v, mPtr[0]);
    @(negedge clk);
    chk({tag, " R10 irq"}, {31'b0, irqDone}, {31'b0, mDone});
    chk({tag, " R8 ready"}, {31'b0, beatReady}, {31'b0, mEn});
    chk({tag, " R3 dir"}, {31'b0, devToMem}, {31'b0, mDir});
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    logic [31:0] v, lim;
    void'($urandom(32'd1234));
    rstN = 0; regSel = 0; regWr = 0; regAddr = '0; regByteEn = 4'hF;
    regWdata = '0; beatValid = 0;
    mEn = 0; mUpd = 0; mDone = 0; mDir = 0;
    for (int i = 0; i < 6; i++) mPtr[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    checkAll("R1");
    for (int i = 0; i < 6; i++) begin
      rd(offOf(i), 4'hF, v);
      chk("R1 ptr", v, 32'h0);
    end

    // R2 set enable, zero leaves it
    wr(15'h0, 32'h1);            checkAll("R2 set");
    wr(15'h0, 32'h0);            checkAll("R2 hold");
    // R3 direction and update, sticky
    wr(15'h0, 32'h12);           checkAll("R3 set");
    wr(15'h0, 32'hFFFF_FF00);    checkAll("R3 sticky");

    // R6 pointer storage
    for (int i = 0; i < 6; i++) wr(offOf(i), 32'hA5C3_0000 + 32'(i * 16));
    for (int i = 0; i < 6; i++) begin
      rd(offOf(i), 4'hF, v);
      chk("R6 readback", v, mPtr[i]);
    end

    // R7 illegal lanes, misalignment, unmapped offsets
    cyc(1, 1, 15'h4004, 4'h3, 32'h1111_1111, 0);
    cyc(1, 1, 15'h4006, 4'hF, 32'h2222_2222, 0);
    cyc(1, 1, 15'h4010, 4'hF, 32'h3333_3333, 0);
    rd(15'h4004, 4'hF, v);  chk("R7 limit untouched", v, mPtr[1]);
    rd(15'h4004, 4'h1, v);  chk("R7 narrow read", v, 32'h0);
    rd(15'h4010, 4'hF, v);  chk("R7 unmapped read", v, 32'h0);

    // R5 reset command, then R8/R9 completion run
    wr(15'h0, 32'h8);            checkAll("R5 reset");
    wr(15'h4004, 32'h0000_00F8);
    wr(15'h4000, 32'h0000_00F0);
    wr(15'h0, 32'h1);
    cyc(0, 0, 0, 4'hF, 0, 1);    checkAll("R8 step");
    cyc(0, 0, 0, 4'hF, 0, 1);    checkAll("R9 done");
    chk("R9 irq high", {31'b0, irqDone}, 32'h1);
    cyc(0, 0, 0, 4'hF, 0, 1);    checkAll("R8 refused");

    // R4 clear-complete touches nothing else
    wr(15'h0, 32'h12);
    wr(15'h0, 32'h4);            checkAll("R4 clear");

    // R5 reset beats set-enable in the same write
    wr(15'h0, 32'h9);            checkAll("R5 priority");

    // R11 write to next in a beat cycle wins; command applied after completion
    wr(15'h0, 32'h1);
    cyc(1, 1, 15'h4000, 4'hF, 32'h0000_0040, 1);  checkAll("R11 write wins");
    wr(15'h4004, 32'h0000_0044);
    cyc(1, 1, 15'h0, 4'hF, 32'h5, 1);             checkAll("R11 cmd after done");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: cyc(1, 1, 15'h0, 4'hF, $urandom, 0);
        1: begin
          lim = {$urandom, 2'b00};
          wr(15'h4004, lim);
          wr(15'h4000, lim - 32'($urandom_range(1, 5) * 4));
          if ($urandom_range(0, 1) == 1) wr(15'h0, 32'h1);
        end
        2: cyc(0, 0, 0, 4'hF, 0, 1);
        3: cyc(1, 1, 15'h0, 4'hF, $urandom & 32'h1F, 1);
        4: wr(offOf($urandom_range(2, 5)), $urandom);
        default: cyc(1, $urandom_range(0, 1) == 1, 15'($urandom),
                      4'($urandom), $urandom, $urandom_range(0, 1) == 1);
      endcase
      checkAll("R9 random");
    end

    finish();
  end

endmodule